// File: doc/BRIEF.md
# Bidirectional Strobed Port Channel

This block is one 8-bit port channel that carries data both ways over a single set of shared pins, with a full handshake on each side. The CPU writes a byte into an output latch, and the channel pulls an active-low "output pending" flag. The peripheral answers with an active-low acknowledge. While acknowledge is held low, the channel drives its pins with the output latch. Outside those intervals the pin output enable is off, so the peripheral can drive the same pins. In the other direction, the peripheral presents a byte and pulses an active-low strobe. The channel captures the pins into a separate input latch and raises an "input full" flag, which stays up until the CPU reads.

A single registered interrupt output combines both directions. The input side requests service when the input latch is full, its enable flag is set, and neither strobe nor read is active. The output side requests service when the output latch is empty, its enable flag is set, and neither acknowledge nor write is active. The two enable flags are written through a bit set/reset command that names a handshake bit position on port C. Bit 6 controls the output enable flag and bit 4 controls the input enable flag. Commands that name any other bit are ignored.

The design is fully synchronous. All strobes are sampled on the rising clock edge, and every flag and pin enable is a register that changes one clock after the sample that causes it.

Top module: `bdport_channel`

## Requirements
- R1: While rst is high and on the first cycle after it, obf_n=1, ibf=0, intr=0, pin_oe=0, pin_out=0 and cpu_rdata=0, and both enable flags are clear.
- R2: A cycle with cpu_wr_n=0 loads cpu_wdata into the output latch, so pin_out shows the byte one clock later and holds it. In that same clock obf_n goes to 0.
- R3: pin_oe is 1 exactly in the clock that follows a sampled ack_n=0, and 0 otherwise.
- R4: ack_n=0 with cpu_wr_n=1 while obf_n=0 returns obf_n to 1 one clock later, and leaves pin_out unchanged.
- R5: ack_n=0 while obf_n=1 changes no flag: obf_n, ibf and pin_out keep their values, and only pin_oe follows R3.
- R6: A cycle with stb_n=0 copies pin_in into the input latch (cpu_rdata) and sets ibf one clock later.
- R7: cpu_rd_n=0 with stb_n=1 clears ibf one clock later. If stb_n=0 in the same cycle, the strobe wins and ibf is 1.
- R8: If cpu_wr_n=0 and ack_n=0 in the same cycle, the write wins: the latch takes the new byte and obf_n is 0.
- R9: Each clock, intr takes the pre-edge value of (ibf & input enable & stb_n & cpu_rd_n) | (obf_n & output enable & ack_n & cpu_wr_n).
- R10: With cmd_we=1, cmd_sel=6 loads cmd_val into the output enable flag and cmd_sel=4 loads it into the input enable flag, both taking effect one clock later. Other cmd_sel values change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_n | input | 1 | CPU write strobe to the output latch, active low |
| cpu_rd_n | input | 1 | CPU read strobe from the input latch, active low |
| cpu_wdata | input | 8 | Byte written by the CPU |
| cpu_rdata | output | 8 | Input latch contents |
| pin_in | input | 8 | Value seen on the shared port pins |
| pin_out | output | 8 | Output latch value for the pin drivers |
| pin_oe | output | 1 | Pin driver enable, high during acknowledge |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output pending flag, active low |
| ibf | output | 1 | Input latch full flag |
| intr | output | 1 | Combined interrupt request |
| cmd_we | input | 1 | Bit set/reset command valid |
| cmd_sel | input | 3 | Port C bit position named by the command |
| cmd_val | input | 1 | Value to set (1) or reset (0) |

## Verification
A wrong output flag shows within one clock. obf_n fails to fall after a write or fails to rise after an acknowledge, and in either case intr then also disagrees on the next clock. A corrupted input latch or ibf shows on cpu_rdata or ibf on the clock after the strobe or read. A wrong enable flag shows only through intr, two clocks after the command, and only when the direction it governs is idle. The bench therefore compares every output with its reference model on every clock. It also drives idle windows after each enable command so that a stuck flag is exposed.

// File: rtl/bdport_pkg.sv
package bdport_pkg;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  // port C positions of the handshake lines; the set/reset decode depends on them
  localparam int PC_INTR = 3;
  localparam int PC_STB  = 4;
  localparam int PC_IBF  = 5;
  localparam int PC_ACK  = 6;
  localparam int PC_OBF  = 7;
  // enable flags share the position of the strobe-side input of each direction
  localparam int EN_IN_BIT  = PC_STB;
  localparam int EN_OUT_BIT = PC_ACK;
endpackage

// File: rtl/bdport_out_side.sv
module bdport_out_side #(
  parameter int DW = bdport_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic          ack_n,
  output logic [DW-1:0] latch_q,
  output logic          obf_n,
  output logic          oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      obf_n   <= 1'b1;
      oe      <= 1'b0;
    end else begin
      oe <= ~ack_n;
      if (!wr_n) begin
        latch_q <= wdata;
        obf_n   <= 1'b0;
      end else if (!ack_n && !obf_n) begin
        obf_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bdport_in_side.sv
module bdport_in_side #(
  parameter int DW = bdport_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic          rd_n,
  input  logic [DW-1:0] pins,
  output logic [DW-1:0] latch_q,
  output logic          ibf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      ibf     <= 1'b0;
    end else if (!stb_n) begin
      latch_q <= pins;
      ibf     <= 1'b1;
    end else if (!rd_n) begin
      ibf <= 1'b0;
    end
  end
endmodule

// File: rtl/bdport_irq.sv
module bdport_irq #(
  parameter int SW = bdport_pkg::SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [SW-1:0] cmd_sel,
  input  logic          cmd_val,
  input  logic          ibf,
  input  logic          obf_n,
  input  logic          stb_n,
  input  logic          rd_n,
  input  logic          ack_n,
  input  logic          wr_n,
  output logic          intr
);
  localparam logic [SW-1:0] SEL_IN  = SW'(bdport_pkg::EN_IN_BIT);
  localparam logic [SW-1:0] SEL_OUT = SW'(bdport_pkg::EN_OUT_BIT);

  logic en_in_q, en_out_q;
  logic req_in, req_out;

  assign req_in  = ibf & en_in_q & stb_n & rd_n;
  assign req_out = obf_n & en_out_q & ack_n & wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_in_q  <= 1'b0;
      en_out_q <= 1'b0;
      intr     <= 1'b0;
    end else begin
      intr <= req_in | req_out;
      if (cmd_we && cmd_sel == SEL_IN)  en_in_q  <= cmd_val;
      if (cmd_we && cmd_sel == SEL_OUT) en_out_q <= cmd_val;
    end
  end
endmodule

// File: rtl/bdport_channel.sv
module bdport_channel #(
  parameter int DW = bdport_pkg::DATA_W,
  parameter int SW = bdport_pkg::SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr_n,
  input  logic          cpu_rd_n,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  input  logic          stb_n,
  input  logic          ack_n,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr,
  input  logic          cmd_we,
  input  logic [SW-1:0] cmd_sel,
  input  logic          cmd_val
);
  bdport_out_side #(.DW(DW)) out_i (
    .clk(clk), .rst(rst), .wr_n(cpu_wr_n), .wdata(cpu_wdata), .ack_n(ack_n),
    .latch_q(pin_out), .obf_n(obf_n), .oe(pin_oe)
  );

  bdport_in_side #(.DW(DW)) in_i (
    .clk(clk), .rst(rst), .stb_n(stb_n), .rd_n(cpu_rd_n), .pins(pin_in),
    .latch_q(cpu_rdata), .ibf(ibf)
  );

  bdport_irq #(.SW(SW)) irq_i (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_val(cmd_val),
    .ibf(ibf), .obf_n(obf_n), .stb_n(stb_n), .rd_n(cpu_rd_n), .ack_n(ack_n),
    .wr_n(cpu_wr_n), .intr(intr)
  );
endmodule

// File: rtl/bdport_channel_chk.sv
module bdport_channel_chk #(
  parameter int DW = bdport_pkg::DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr_n,
  input logic          cpu_rd_n,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic [DW-1:0] pin_in,
  input logic [DW-1:0] pin_out,
  input logic          pin_oe,
  input logic          stb_n,
  input logic          ack_n,
  input logic          obf_n,
  input logic          ibf
);
  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr_n |=> (!obf_n && pin_out == $past(cpu_wdata)));

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == !$past(ack_n)));

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && cpu_wr_n && !obf_n) |=> (obf_n && $stable(pin_out)));

  // R6
  strobe_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_n |=> (ibf && cpu_rdata == $past(pin_in)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_n && !cpu_rd_n) |=> !ibf);
endmodule

bind bdport_channel bdport_channel_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .stb_n(stb_n), .ack_n(ack_n),
  .obf_n(obf_n), .ibf(ibf)
);

// File: tb/bdport_channel_tb_top.sv
module bdport_channel_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       wr_n = 1'b1, rd_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] wdata = '0, pin_in = '0;
  logic       cmd_we = 1'b0, cmd_val = 1'b0;
  logic [2:0] cmd_sel = '0;
  logic [7:0] rdata, pin_out;
  logic       pin_oe, obf_n, ibf, intr;

  bdport_channel dut_i (
    .clk(clk), .rst(rst), .cpu_wr_n(wr_n), .cpu_rd_n(rd_n), .cpu_wdata(wdata),
    .cpu_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .intr(intr),
    .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_val(cmd_val)
  );

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  // behavioural reference
  int m_out = 0, m_in = 0;
  bit m_obf_n = 1, m_ibf = 0, m_oe = 0, m_intr = 0, m_en_in = 0, m_en_out = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_out = 0; m_in = 0; m_obf_n = 1; m_ibf = 0; m_oe = 0; m_intr = 0;
      m_en_in = 0; m_en_out = 0;
    end else begin
      m_intr = (m_ibf && m_en_in && stb_n && rd_n) ||
               (m_obf_n && m_en_out && ack_n && wr_n);
      m_oe = !ack_n;
      if (!wr_n) begin m_out = wdata; m_obf_n = 0; end
      else if (!ack_n && !m_obf_n) m_obf_n = 1;
      if (!stb_n) begin m_in = pin_in; m_ibf = 1; end
      else if (!rd_n) m_ibf = 0;
      if (cmd_we && cmd_sel == 3'd6) m_en_out = cmd_val;
      if (cmd_we && cmd_sel == 3'd4) m_en_in = cmd_val;
    end
    started = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check(obf_n == m_obf_n, "R2 obf_n", obf_n, m_obf_n);
    check(pin_out == m_out[7:0], "R2 pin_out", pin_out, m_out);
    check(pin_oe == m_oe, "R3 pin_oe", pin_oe, m_oe);
    check(ibf == m_ibf, "R6 ibf", ibf, m_ibf);
    check(rdata == m_in[7:0], "R6 cpu_rdata", rdata, m_in);
    check(intr == m_intr, "R9 intr", intr, m_intr);
  end

  task automatic step(input bit w, input int d, input bit a, input bit s,
                      input int p, input bit r, input bit cw, input int cs, input bit cv);
    wr_n = w; wdata = d[7:0]; ack_n = a; stb_n = s; pin_in = p[7:0]; rd_n = r;
    cmd_we = cw; cmd_sel = cs[2:0]; cmd_val = cv;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, 1, 0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(obf_n == 1 && ibf == 0 && intr == 0 && pin_oe == 0, "R1 reset flags",
          {obf_n, ibf, intr, pin_oe}, 4'b1000);
    rst = 1'b0;
    idle(1);
    check(pin_out == 0 && rdata == 0, "R1 reset latches", {pin_out, rdata}, 0);
    check(intr == 0, "R1 enables clear", intr, 0);
    // R10: other bit positions ignored
    step(1, 0, 1, 1, 0, 1, 1, 2, 1);
    step(1, 0, 1, 1, 0, 1, 1, 7, 1);
    idle(2);
    check(intr == 0, "R10 ignored select", intr, 0);
    step(1, 0, 1, 1, 0, 1, 1, 6, 1);
    idle(1);
    check(intr == 1, "R10 output enable set", intr, 1);
    // R2 write
    step(0, 'hA5, 1, 1, 0, 1, 0, 0, 0);
    check(obf_n == 0 && pin_out == 8'hA5, "R2 write", {obf_n, pin_out}, 9'h0A5);
    idle(1);
    check(intr == 0, "R9 pending output no intr", intr, 0);
    // R3/R4 acknowledge
    step(1, 0, 0, 1, 0, 1, 0, 0, 0);
    check(pin_oe == 1 && obf_n == 1 && pin_out == 8'hA5, "R4 ack release",
          {pin_oe, obf_n, pin_out}, 10'h3A5);
    idle(1);
    check(pin_oe == 0, "R3 oe off", pin_oe, 0);
    idle(1);
    check(intr == 1, "R9 empty output intr", intr, 1);
    // R5 stray acknowledge
    step(1, 0, 0, 1, 0, 1, 0, 0, 0);
    check(obf_n == 1 && ibf == 0 && pin_out == 8'hA5 && pin_oe == 1, "R5 stray ack",
          {obf_n, ibf, pin_out}, 10'h2A5);
    // R8 write and ack together
    step(0, 'h3C, 0, 1, 0, 1, 0, 0, 0);
    check(obf_n == 0 && pin_out == 8'h3C, "R8 write wins", {obf_n, pin_out}, 9'h03C);
    step(1, 0, 0, 1, 0, 1, 1, 6, 0);
    idle(2);
    check(intr == 0, "R10 output enable cleared", intr, 0);
    // R6/R7 input side
    step(1, 0, 1, 1, 0, 1, 1, 4, 1);
    step(1, 0, 1, 0, 'h5A, 1, 0, 0, 0);
    check(ibf == 1 && rdata == 8'h5A, "R6 strobe", {ibf, rdata}, 9'h15A);
    idle(1);
    check(intr == 1, "R9 input full intr", intr, 1);
    step(1, 0, 1, 1, 0, 0, 0, 0, 0);
    check(ibf == 0, "R7 read clears", ibf, 0);
    step(1, 0, 1, 0, 'hC3, 0, 0, 0, 0);
    check(ibf == 1 && rdata == 8'hC3, "R7 strobe wins", {ibf, rdata}, 9'h1C3);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom, ($urandom % 4) != 0, ($urandom % 5) != 0,
           $urandom, ($urandom % 4) != 0, ($urandom % 6) == 0, $urandom % 8, $urandom % 2);
    end
    rst = 1'b1;
    idle(1);
    check(obf_n == 1 && ibf == 0 && intr == 0 && pin_oe == 0, "R1 re-reset",
          {obf_n, ibf, intr, pin_oe}, 4'b1000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule